// File: doc/BRIEF.md
# Ready-Flagged Chainable FIFO Buffer

This block is a small first-in first-out store with separate load and unload strobes. By default it holds sixteen words of four bits. Two flags report its state. An input-ready flag says that a new word can be taken. An output-ready flag says that the oldest stored word is on the data outputs. Both strobes are sampled on one system clock. Each strobe acts once, on its rising edge, and only while its own flag is high. An active-low master reset empties the buffer. An active-high output enable lets the data through to the outputs, and forces them to zero when it is low.

The flags are built for chaining. After each accepted load, input-ready falls for one cycle. After each accepted unload, output-ready falls for one cycle. A link signal formed as `upstream out_rdy AND downstream in_rdy` therefore pulses once for each word that moves. That one link drives both the downstream load strobe and the upstream unload strobe. Stages then pass words along in depth without any other glue.

To build a wider word, place units side by side. AND the input-ready flags of the first row, and AND the output-ready flags of the last row. Each unit then sees a common strobe and moves in step with the others.

Top module: `chain_fifo`

## Requirements
- R1: Words leave in the order they were accepted. Data is WIDTH bits wide (4 by default), and DEPTH words (16 by default) can be held at once.
- R2: A load is taken only on a rising edge of `load_strb` (high now, low in the previous cycle) while `in_rdy` is high. Holding the strobe high for several cycles stores exactly one word.
- R3: `in_rdy` is high while fewer than DEPTH words are stored, except during the cycle that follows an accepted load. It stays high at DEPTH-1 words and is low at DEPTH words. A load strobe given while the buffer is full changes nothing.
- R4: `out_rdy` is high while at least one word is stored, except during the cycle that follows an accepted unload. An unload strobe given while `out_rdy` is low changes nothing.
- R5: While `rst_n` is low, the buffer becomes empty, `in_rdy` is 1 and `out_rdy` is 0. The data is then zero, with `oe` high.
- R6: With `oe` low, `dout` is all zeros. With `oe` high, `dout` shows the oldest stored word.
- R7: A load and an unload accepted at the same clock edge leave the occupancy unchanged and advance both pointers.
- R8: A word loaded into an empty buffer at one clock edge raises `out_rdy` right after that edge and appears on `dout`.
- R9: Units can be chained in depth with `link = up.out_rdy & dn.in_rdy` driving both `dn.load_strb` and `up.unload_strb`. Two default units then hold 32 words, keep their order, and report `in_rdy` low at the head when full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| load_strb | input | 1 | Load strobe, acts on its rising edge |
| unload_strb | input | 1 | Unload strobe, acts on its rising edge |
| din | input | WIDTH | Word to store |
| oe | input | 1 | Output enable, active high |
| dout | output | WIDTH | Oldest word, or zero when disabled |
| in_rdy | output | 1 | Buffer can take a word |
| out_rdy | output | 1 | A valid word is on `dout` |

## Verification
The design keeps its state in a read pointer, a write pointer and an occupancy count, and an error in any of them reaches the ports quickly. A wrong read pointer changes `dout` at the very next unload, and a drain in order exposes it. A wrong count shows up as a flag at the wrong time. It is visible within one cycle at the 0, 1, DEPTH-1 and DEPTH word boundaries: `out_rdy` stays high on an empty buffer, or `in_rdy` stays high on a full one. A broken strobe edge detector stores duplicate words from one held strobe. A missing recovery cycle lets the chained link move a word twice, which appears as a duplicate or a lost word when the downstream unit is drained.

// File: rtl/cf_pkg.sv
package cf_pkg;

  typedef struct packed {
    logic load;
    logic unload;
  } xfer_t;

  function automatic logic [31:0] wrap_inc(input logic [31:0] p, input int unsigned depth);
    return (p == depth - 1) ? 32'd0 : p + 32'd1;
  endfunction

  function automatic logic [31:0] next_fill(input logic [31:0] c, input xfer_t x);
    logic [31:0] r;
    r = c;
    if (x.load && !x.unload) r = c + 32'd1;
    if (x.unload && !x.load) r = c - 32'd1;
    return r;
  endfunction

endpackage

// File: rtl/cf_strobe_edge.sv
module cf_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= strobe;
  end

  assign rise = strobe & ~prev_q;
endmodule

// File: rtl/cf_occupancy.sv
module cf_occupancy #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_ev,
  input  logic          unload_ev,
  output logic          load_ok,
  output logic          unload_ok,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          in_rdy,
  output logic          out_rdy
);
  import cf_pkg::*;

  logic  ld_rec, ul_rec;
  xfer_t xf;

  assign in_rdy    = (count != CW'(DEPTH)) && !ld_rec;
  assign out_rdy   = (count != '0) && !ul_rec;
  assign load_ok   = load_ev & in_rdy;
  assign unload_ok = unload_ev & out_rdy;
  assign xf        = '{load: load_ok, unload: unload_ok};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ld_rec <= 1'b0;
      ul_rec <= 1'b0;
    end else begin
      if (load_ok)   wr_ptr <= AW'(wrap_inc(32'(wr_ptr), DEPTH));
      if (unload_ok) rd_ptr <= AW'(wrap_inc(32'(rd_ptr), DEPTH));
      count  <= CW'(next_fill(32'(count), xf));
      ld_rec <= load_ok;
      ul_rec <= unload_ok;
    end
  end
endmodule

// File: rtl/cf_store.sv
module cf_store #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/chain_fifo.sv
module chain_fifo #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_strb,
  input  logic             unload_strb,
  input  logic [WIDTH-1:0] din,
  input  logic             oe,
  output logic [WIDTH-1:0] dout,
  output logic             in_rdy,
  output logic             out_rdy
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [1:0]       strobes, rises;
  logic             load_ok, unload_ok;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic [WIDTH-1:0] head;

  assign strobes = {unload_strb, load_strb};

  for (genvar g = 0; g < 2; g++) begin : g_edge
    cf_strobe_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (strobes[g]),
      .rise   (rises[g])
    );
  end

  cf_occupancy #(.DEPTH(DEPTH)) u_occ (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_ev   (rises[0]),
    .unload_ev (rises[1]),
    .load_ok   (load_ok),
    .unload_ok (unload_ok),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .count     (count),
    .in_rdy    (in_rdy),
    .out_rdy   (out_rdy)
  );

  cf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (load_ok),
    .waddr (wr_ptr),
    .wdata (din),
    .raddr (rd_ptr),
    .rdata (head)
  );

  assign dout = oe ? head : '0;
endmodule

// File: rtl/chain_fifo_chk.sv
module chain_fifo_chk #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_rdy,
  input logic          out_rdy,
  input logic          load_ok,
  input logic          unload_ok,
  input logic [CW-1:0] count
);
  assert_fill_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ok && !unload_ok) |=> (count == $past(count) + CW'(1)));

  assert_drain_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (unload_ok && !load_ok) |=> (count == $past(count) - CW'(1)));

  assert_both_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ok && unload_ok) |=> $stable(count));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_one_per_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> !load_ok);

  assert_unload_recover_R4: assert property (@(posedge clk) disable iff (!rst_n)
    unload_ok |=> !out_rdy);

  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH)) |-> !in_rdy);

  assert_empty_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !out_rdy);
endmodule

bind chain_fifo chain_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_rdy    (in_rdy),
  .out_rdy   (out_rdy),
  .load_ok   (load_ok),
  .unload_ok (unload_ok),
  .count     (count)
);

// File: tb/tb_chain_fifo.sv
module tb_chain_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_strb = 1'b0, unload_strb = 1'b0, oe = 1'b1;
  logic [3:0] din = '0;
  logic [3:0] dout;
  logic       in_rdy, out_rdy;

  // cascade pair
  logic       c_ld = 1'b0, c_ul = 1'b0;
  logic [3:0] c_din = '0;
  logic [3:0] up_dout, dn_dout;
  logic       up_in, up_out, dn_in, dn_out, link;

  int nvec = 0, nbad = 0;
  bit done = 0;
  logic [3:0] mq[$];

  always #5 clk = ~clk;

  chain_fifo dut (.clk(clk), .rst_n(rst_n), .load_strb(load_strb), .unload_strb(unload_strb),
    .din(din), .oe(oe), .dout(dout), .in_rdy(in_rdy), .out_rdy(out_rdy));

  assign link = up_out & dn_in;

  chain_fifo c_up (.clk(clk), .rst_n(rst_n), .load_strb(c_ld), .unload_strb(link),
    .din(c_din), .oe(1'b1), .dout(up_dout), .in_rdy(up_in), .out_rdy(up_out));

  chain_fifo c_dn (.clk(clk), .rst_n(rst_n), .load_strb(link), .unload_strb(c_ul),
    .din(up_dout), .oe(1'b1), .dout(dn_dout), .in_rdy(dn_in), .out_rdy(dn_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [3:0] d);
    @(negedge clk);
    din = d; load_strb = 1'b1;
    if (mq.size() < 16) mq.push_back(d);
    @(negedge clk); load_strb = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_unload(input string req);
    @(negedge clk);
    chk({req, " out_rdy"}, 32'(out_rdy), 1);
    chk({req, " data"}, 32'(dout), 32'(mq[0]));
    unload_strb = 1'b1;
    void'(mq.pop_front());
    @(negedge clk); unload_strb = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R5 in_rdy", 32'(in_rdy), 1);
    chk("R5 out_rdy", 32'(out_rdy), 0);
    chk("R5 dout", 32'(dout), 0);
    rst_n = 1'b1;
    mq.delete();
  endtask

  task automatic t_fill_drain;
    do_load(4'h3);
    chk("R8 out_rdy after first load", 32'(out_rdy), 1);
    chk("R8 data after first load", 32'(dout), 3);
    for (int i = 1; i < 16; i++) begin
      do_load(4'(i * 7 + 2));
      if (i == 14) chk("R3 in_rdy at 15 words", 32'(in_rdy), 1);
    end
    chk("R3 in_rdy at full", 32'(in_rdy), 0);
    do_load(4'hF);  // ignored: model already holds 16
    chk("R3 in_rdy still full", 32'(in_rdy), 0);
    for (int i = 0; i < 16; i++) do_unload("R1 drain order");
    chk("R4 out_rdy empty", 32'(out_rdy), 0);
    chk("R3 in_rdy empty", 32'(in_rdy), 1);
  endtask

  task automatic t_gate;
    do_load(4'hA);
    @(negedge clk); oe = 1'b0;
    #1 chk("R6 gated dout", 32'(dout), 0);
    chk("R6 out_rdy while gated", 32'(out_rdy), 1);
    oe = 1'b1;
    #1 chk("R6 enabled dout", 32'(dout), 32'hA);
    do_unload("R6 drain");
  endtask

  task automatic t_simul;
    do_load(4'h1); do_load(4'h2); do_load(4'h3);
    @(negedge clk);
    chk("R7 head before", 32'(dout), 1);
    din = 4'h4; load_strb = 1'b1; unload_strb = 1'b1;
    mq.push_back(4'h4); void'(mq.pop_front());
    @(negedge clk); load_strb = 1'b0; unload_strb = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) do_unload("R7 after simultaneous");
    chk("R7 empty after three", 32'(out_rdy), 0);
  endtask

  task automatic t_held;
    @(negedge clk); din = 4'h7; load_strb = 1'b1;
    mq.push_back(4'h7);
    repeat (4) @(negedge clk);
    load_strb = 1'b0;
    @(negedge clk);
    do_unload("R2 held strobe");
    chk("R2 single word only", 32'(out_rdy), 0);
  endtask

  task automatic t_empty_unload;
    @(negedge clk); unload_strb = 1'b1;
    @(negedge clk); unload_strb = 1'b0;
    @(negedge clk);
    chk("R4 still empty", 32'(out_rdy), 0);
    do_load(4'h9);
    do_unload("R4 word after empty unload");
    chk("R4 empty again", 32'(out_rdy), 0);
  endtask

  task automatic t_reset_mid;
    do_load(4'h5); do_load(4'h6);
    do_reset();
    @(negedge clk);
    chk("R5 empty after release", 32'(out_rdy), 0);
  endtask

  task automatic t_cascade;
    logic [3:0] cq[$];
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      while (!up_in) @(negedge clk);
      c_din = 4'(i * 5 + 1); c_ld = 1'b1; cq.push_back(c_din);
      @(negedge clk); c_ld = 1'b0;
    end
    repeat (80) @(negedge clk);
    chk("R9 head full at 32", 32'(up_in), 0);
    chk("R9 tail ready", 32'(dn_out), 1);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      while (!dn_out) @(negedge clk);
      chk("R9 chain order", 32'(dn_dout), 32'(cq.pop_front()));
      c_ul = 1'b1;
      @(negedge clk); c_ul = 1'b0;
    end
    repeat (80) @(negedge clk);
    chk("R9 chain drained", 32'(dn_out), 0);
    chk("R9 head ready again", 32'(up_in), 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_fill_drain();
    t_gate();
    t_simul();
    t_held();
    t_empty_unload();
    t_reset_mid();
    t_cascade();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule